// File: doc/BRIEF.md
# Byte-Write Threshold DAC Link Bridge

This block sits between a host bus that can only write or read one byte at a time and four remote threshold DAC cards. Each card is reached over its own serial link made of a frame select, a serial clock, outgoing data and returning data. The host addresses a card with a 2-bit subaddress. It writes three bytes to that subaddress to form one 24-bit DAC command. The block cleans up the fixed fields of the command and shifts it out on the chosen link, most significant bit first.

A command with its read/write bit set asks the DAC to return a register. For such a request the block runs a longer 32-bit transfer and gathers the returning bits from the single link chosen by a static select input. The host then reads four bytes. The first byte only covers the cable round-trip delay and is thrown away. The next three bytes carry the returned word, high byte first.

While a transfer is running the block reports busy. It refuses host writes during that time and records each refused write in a sticky overrun flag.

Top module: `thrdac_bridge`

## Requirements
- R1: A frame goes out only on the link whose number equals the subaddress of its three writes. Every other link keeps frame select high, serial clock low and outgoing data low.
- R2: The first of three accepted writes to one subaddress becomes command bits 23:16, the second becomes bits 15:8 and the third becomes bits 7:0. The third write starts the transfer, and busy is high from the next cycle on.
- R3: The command is shifted most significant bit first. Bits 23, 21, 20, 1 and 0 always go out as zero. Bit 22 is the read/write flag (1 = read request), bits 19:16 are the channel and bits 15:14 are the register select; all of these go out as written.
- R4: When bit 22 is 1, bits 13:2 go out as zero and the transfer lasts 32 serial clocks, with outgoing data zero for the final 8.
- R5: Frame select falls in the cycle after the third write. The first rising serial-clock edge comes HALF cycles later, and each serial-clock level lasts HALF cycles. Outgoing data changes only on falling edges. Frame select returns high and busy drops 2·N·HALF cycles after the start, where N is 24 or 32, with the serial clock low.
- R6: On every rising serial-clock edge the block samples the returning data of link rb_sel. After a read transfer, rd_data shows the first 8 sampled bits, which are the delay slot. Each rd_en pulse moves rd_data on to the next 8 bits and wraps after four reads. Without rd_en, rd_data holds its value.
- R7: When a read transfer ends, the byte pointer goes back to the first byte. A write transfer leaves rd_data unchanged.
- R8: A host write that arrives while busy is high is ignored and does not advance the byte count. It sets the overrun output, which stays set until reset.
- R9: A write to another subaddress while a command is part-built throws away the earlier bytes and counts as the first byte of a new command.
- R10: After reset, busy, overrun, every serial clock, all outgoing data and rd_data are 0, and every frame select is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host byte-write strobe |
| wr_sub | input | 2 | Subaddress (link number) of the write |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Host byte-read strobe, advances the readback byte |
| rd_data | output | 8 | Current readback byte |
| rb_sel | input | 2 | Static choice of the link whose return data is sampled |
| busy | output | 1 | Transfer in progress |
| overrun | output | 1 | Sticky flag: a write arrived while busy |
| cs_n | output | 4 | Per-link frame select, active low |
| sclk | output | 4 | Per-link serial clock |
| mosi | output | 4 | Per-link outgoing serial data |
| miso | input | 4 | Per-link returning serial data |

## Verification
The third write is registered at one clock edge, so busy and the frame select are checked at the falling clock edge that follows. The bench then counts falling edges. It expects the first high serial clock at count HALF and the released frame select at count 2·N·HALF. It samples outgoing data at the first falling clock edge on which it sees the serial clock high. It drives returning data only at falling clock edges, so the value is settled before each rising serial-clock edge samples it. rd_data is combinational from the readback register, so it is checked at the falling edge before each rd_en pulse and again once the pulse has been registered.

// File: rtl/thrdac_pkg.sv
package thrdac_pkg;

  localparam int CMD_W  = 24;
  localparam int CAP_W  = 32;
  localparam int BYTE_W = 8;

  // Force the fixed fields of a command; a read request clears its data field.
  function automatic logic [CMD_W-1:0] frame_fix(input logic [CMD_W-1:0] raw);
    logic [CMD_W-1:0] w;
    w       = raw;
    w[23]   = 1'b0;
    w[21:20] = 2'b00;
    w[1:0]  = 2'b00;
    if (w[22]) w[13:2] = '0;
    return w;
  endfunction

  // Serial clock count of a transfer.
  function automatic int unsigned frame_bits(input logic is_read);
    return is_read ? CAP_W : CMD_W;
  endfunction

  // Byte number idx of a captured word, counted from the first bit in.
  function automatic logic [BYTE_W-1:0] byte_pick(input logic [CAP_W-1:0] v,
                                                  input logic [1:0] idx);
    logic [CAP_W-1:0] s;
    s = v << {idx, 3'b000};
    return s[CAP_W-1 -: BYTE_W];
  endfunction

endpackage

// File: rtl/thrdac_packer.sv
module thrdac_packer #(
  parameter int SUB_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SUB_W-1:0] wr_sub,
  input  logic [7:0]       wr_data,
  input  logic             busy,
  output logic             start,
  output logic [SUB_W-1:0] start_sub,
  output logic [23:0]      start_word,
  output logic             overrun
);

  logic [1:0]       cnt;
  logic [SUB_W-1:0] sub_r;
  logic [15:0]      acc;

  wire accept = wr_en && !busy;
  wire same   = (wr_sub == sub_r);

  assign start      = accept && (cnt == 2'd2) && same;
  assign start_sub  = wr_sub;
  assign start_word = {acc, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sub_r   <= '0;
      acc     <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr_en && busy) overrun <= 1'b1;
      if (accept) begin
        if (cnt == 2'd0 || !same) begin
          acc[15:8] <= wr_data;
          sub_r     <= wr_sub;
          cnt       <= 2'd1;
        end else if (cnt == 2'd1) begin
          acc[7:0] <= wr_data;
          cnt      <= 2'd2;
        end else begin
          cnt <= 2'd0;
        end
      end
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != 2'd3);
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cnt));
  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

endmodule

// File: rtl/thrdac_shifter.sv
module thrdac_shifter
  import thrdac_pkg::*;
#(
  parameter int SUB_W = 2,
  parameter int HALF  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SUB_W-1:0] start_sub,
  input  logic [CMD_W-1:0] start_word,
  input  logic             miso_in,
  output logic             busy,
  output logic [SUB_W-1:0] link,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             done,
  output logic             rd_frame,
  output logic [CAP_W-1:0] cap
);

  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int PW = $clog2(2 * CAP_W);

  logic [DW-1:0]    div_cnt;
  logic [PW-1:0]    ph;
  logic [CAP_W-1:0] sh_out;

  wire tick = busy && (div_cnt == DW'(HALF - 1));
  wire last = (ph == PW'(2 * frame_bits(rd_frame) - 1));

  assign done   = tick && last;
  assign mosi_o = sh_out[CAP_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      link     <= '0;
      sclk_o   <= 1'b0;
      sh_out   <= '0;
      cap      <= '0;
      div_cnt  <= '0;
      ph       <= '0;
      rd_frame <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      link     <= start_sub;
      sclk_o   <= 1'b0;
      sh_out   <= {frame_fix(start_word), 8'h00};
      rd_frame <= start_word[22];
      div_cnt  <= '0;
      ph       <= '0;
    end else if (busy) begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) begin
        if (last) begin
          busy   <= 1'b0;
          sclk_o <= 1'b0;
          sh_out <= '0;
        end else begin
          ph     <= ph + 1'b1;
          sclk_o <= ~sclk_o;
          if (sclk_o) sh_out <= sh_out << 1;
          else        cap    <= {cap[CAP_W-2:0], miso_in};
        end
      end
    end
  end

  assert_sclk_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sclk_o) && $stable(mosi_o));
  assert_end_from_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sclk_o);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk_o && !mosi_o);

endmodule

// File: rtl/thrdac_retbuf.sv
module thrdac_retbuf
  import thrdac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CAP_W-1:0] din,
  input  logic             rd_en,
  output logic [7:0]       rd_data
);

  logic [CAP_W-1:0] ret;
  logic [1:0]       ptr;

  assign rd_data = byte_pick(ret, ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret <= '0;
      ptr <= '0;
    end else if (load) begin
      ret <= din;
      ptr <= '0;
    end else if (rd_en) begin
      ptr <= ptr + 1'b1;
    end
  end

  assert_ptr_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr == 2'd0));
  assert_hold_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !rd_en) |=> $stable(rd_data));

endmodule

// File: rtl/thrdac_bridge.sv
module thrdac_bridge
  import thrdac_pkg::*;
#(
  parameter int NLINK = 4,
  parameter int HALF  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(NLINK)-1:0] wr_sub,
  input  logic [7:0]               wr_data,
  input  logic                     rd_en,
  output logic [7:0]               rd_data,
  input  logic [$clog2(NLINK)-1:0] rb_sel,
  output logic                     busy,
  output logic                     overrun,
  output logic [NLINK-1:0]         cs_n,
  output logic [NLINK-1:0]         sclk,
  output logic [NLINK-1:0]         mosi,
  input  logic [NLINK-1:0]         miso
);

  localparam int SUB_W = $clog2(NLINK);

  logic             start;
  logic [SUB_W-1:0] start_sub;
  logic [CMD_W-1:0] start_word;
  logic [SUB_W-1:0] link;
  logic             sclk_c, mosi_c, done, rd_frame;
  logic [CAP_W-1:0] cap;

  wire miso_pick = miso[rb_sel];
  wire ret_load  = done && rd_frame;

  thrdac_packer #(.SUB_W(SUB_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sub(wr_sub), .wr_data(wr_data),
    .busy(busy), .start(start), .start_sub(start_sub), .start_word(start_word),
    .overrun(overrun)
  );

  thrdac_shifter #(.SUB_W(SUB_W), .HALF(HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .start_sub(start_sub),
    .start_word(start_word), .miso_in(miso_pick), .busy(busy), .link(link),
    .sclk_o(sclk_c), .mosi_o(mosi_c), .done(done), .rd_frame(rd_frame), .cap(cap)
  );

  thrdac_retbuf u_ret (
    .clk(clk), .rst_n(rst_n), .load(ret_load), .din(cap), .rd_en(rd_en),
    .rd_data(rd_data)
  );

  for (genvar i = 0; i < NLINK; i++) begin : g_link
    wire sel = busy && (link == SUB_W'(i));
    assign cs_n[i] = !sel;
    assign sclk[i] = sel && sclk_c;
    assign mosi[i] = sel && mosi_c;
  end

  assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  assert_start_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && !cs_n[link] && !sclk[link]);
  assert_one_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

endmodule

// File: tb/sim_thrdac_bridge.sv
module sim_thrdac_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sub = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [1:0] rb_sel = '0;
  logic [3:0] miso_tb = '0;
  logic [7:0] rd_data;
  logic       busy, overrun;
  logic [3:0] cs_n, sclk, mosi;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thrdac_bridge #(.NLINK(4), .HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sub(wr_sub), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rb_sel(rb_sel), .busy(busy),
    .overrun(overrun), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso_tb)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expect_cmd(input logic [7:0] b0, input logic [7:0] b1,
                                             input logic [7:0] b2);
    logic [23:0] c;
    c = {b0 & 8'b0100_1111, b1, b2 & 8'b1111_1100};
    if (b0[6]) c = {c[23:14], 14'd0};
    return c;
  endfunction

  task automatic wr_byte(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sub = s; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_byte(input logic [7:0] exp, input string req);
    check(rd_data === exp, req, rd_data, exp);
    rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Called at the falling edge just after the third write; observes one transfer.
  task automatic run_frame(input logic [1:0] s, input logic [23:0] cmd, input bit rd,
                           input logic [31:0] pat);
    int n, c, nr, first_rise, idle_bad;
    logic prev;
    logic [31:0] got, want;
    n = rd ? 32 : 24;
    want = {cmd, 8'h00};
    got = '0; c = 0; nr = 0; first_rise = -1; idle_bad = 0; prev = 1'b0;
    check(busy === 1'b1 && cs_n[s] === 1'b0, "R5 open", {busy, cs_n}, {1'b1, 4'h0});
    for (int i = 0; i < 4; i++) miso_tb[i] = (i == rb_sel) ? pat[31] : ~pat[31];
    while (cs_n[s] === 1'b0 && c < 1000) begin
      for (int i = 0; i < 4; i++)
        if (i != s && (cs_n[i] !== 1'b1 || sclk[i] !== 1'b0 || mosi[i] !== 1'b0))
          idle_bad++;
      if (sclk[s] && !prev) begin
        if (first_rise < 0) first_rise = c;
        if (nr < 32) got[31-nr] = mosi[s];
        nr++;
      end
      prev = sclk[s];
      for (int i = 0; i < 4; i++)
        miso_tb[i] = (nr < 32) ? ((i == rb_sel) ? pat[31-nr] : ~pat[31-nr]) : 1'b0;
      @(negedge clk);
      c++;
    end
    check(idle_bad == 0, "R1 other links idle", idle_bad, 0);
    check(first_rise == HALF, "R5 first rise", first_rise, HALF);
    check(c == 2*n*HALF, "R5 frame length", c, 2*n*HALF);
    check(busy === 1'b0 && sclk[s] === 1'b0, "R5 end", {busy, sclk[s]}, 0);
    check(nr == n, "R4 clock count", nr, n);
    check(got == want, rd ? "R4 read frame bits" : "R3 frame bits", got, want);
  endtask

  task automatic t_reset;
    check(busy === 1'b0 && overrun === 1'b0, "R10 flags", {busy, overrun}, 0);
    check(cs_n === 4'hF && sclk === 4'h0 && mosi === 4'h0, "R10 links",
          {cs_n, sclk, mosi}, {4'hF, 8'h00});
    check(rd_data === 8'h00, "R10 rd_data", rd_data, 0);
  endtask

  task automatic t_write_frames;
    wr_byte(2'd0, 8'hB5); wr_byte(2'd0, 8'hA7);
    check(busy === 1'b0, "R2 no launch before third", busy, 0);
    wr_byte(2'd0, 8'h3F);
    run_frame(2'd0, expect_cmd(8'hB5, 8'hA7, 8'h3F), 1'b0, 32'h0);
    wr_byte(2'd3, 8'h0C); wr_byte(2'd3, 8'h5A); wr_byte(2'd3, 8'hC3);
    run_frame(2'd3, expect_cmd(8'h0C, 8'h5A, 8'hC3), 1'b0, 32'h0);
  endtask

  task automatic t_readback;
    rb_sel = 2'd2;
    wr_byte(2'd2, 8'h4F); wr_byte(2'd2, 8'hFF); wr_byte(2'd2, 8'hFF);
    run_frame(2'd2, 24'h4FC000, 1'b1, 32'hA53C_96E1);
    rd_byte(8'hA5, "R6 delay slot byte");
    rd_byte(8'h3C, "R6 byte 1");
    rd_byte(8'h96, "R6 byte 2");
    rd_byte(8'hE1, "R6 byte 3");
    check(rd_data === 8'hA5, "R6 wrap", rd_data, 8'hA5);
  endtask

  task automatic t_ret_rules;
    wr_byte(2'd1, 8'h01); wr_byte(2'd1, 8'h23); wr_byte(2'd1, 8'h45);
    run_frame(2'd1, expect_cmd(8'h01, 8'h23, 8'h45), 1'b0, 32'h1234_5678);
    check(rd_data === 8'hA5, "R7 write frame keeps readback", rd_data, 8'hA5);
    rd_byte(8'hA5, "R7 pre-read");
    check(rd_data === 8'h3C, "R6 advance", rd_data, 8'h3C);
    wr_byte(2'd2, 8'h40); wr_byte(2'd2, 8'h80); wr_byte(2'd2, 8'h00);
    run_frame(2'd2, 24'h408000, 1'b1, 32'h5E6F_7081);
    check(rd_data === 8'h5E, "R7 pointer reset", rd_data, 8'h5E);
  endtask

  task automatic t_overrun;
    int w;
    check(overrun === 1'b0, "R8 clear before", overrun, 0);
    wr_byte(2'd0, 8'h0A); wr_byte(2'd0, 8'h11); wr_byte(2'd0, 8'h22);
    wr_byte(2'd1, 8'h33); wr_byte(2'd1, 8'h44);
    w = 0;
    while (busy === 1'b1 && w < 1000) begin @(negedge clk); w++; end
    check(overrun === 1'b1, "R8 overrun set", overrun, 1);
    wr_byte(2'd1, 8'h05);
    check(busy === 1'b0 && cs_n === 4'hF, "R8 ignored writes not counted",
          {busy, cs_n}, {1'b0, 4'hF});
    wr_byte(2'd1, 8'h66); wr_byte(2'd1, 8'h77);
    run_frame(2'd1, expect_cmd(8'h05, 8'h66, 8'h77), 1'b0, 32'h0);
    check(overrun === 1'b1, "R8 sticky", overrun, 1);
  endtask

  task automatic t_restart;
    wr_byte(2'd0, 8'hEE); wr_byte(2'd0, 8'hDD);
    wr_byte(2'd2, 8'h03); wr_byte(2'd2, 8'h9C);
    check(busy === 1'b0, "R9 restart no early launch", busy, 0);
    wr_byte(2'd2, 8'hF0);
    run_frame(2'd2, expect_cmd(8'h03, 8'h9C, 8'hF0), 1'b0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write_frames();
    t_readback();
    t_ret_rules();
    t_overrun();
    t_restart();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule